// File: doc/BRIEF.md
# Incremental Encoder Position Counter with Index Preset

This block keeps a 32-bit signed-agnostic position count for an incremental encoder. The two track inputs are read either as a quadrature pair, at one, two or four counts per quadrature cycle, or as two independent pulse lines, one for each direction. The index track can load a preset position, so the count can be re-referenced once per revolution. The load only happens while the two tracks show one chosen level combination, and it can also be made to wait for an external homing input.

All four encoder inputs are asynchronous to the clock. Each one passes through a two-flop synchroniser before any edge is decoded. A pair of track changes that skips a quadrature state cannot be decoded, so it is ignored and recorded in a flag. The flag stays set until reset.

Top module: `quad_pos_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `count` becomes 0 and `err` becomes 0. Both hold those values until the first qualifying input activity after reset.
- R2: With `mode_sel` = 2'b00 (single resolution), a change of the synchronised {A,B} from 2'b00 to 2'b10 adds 1 and a change from 2'b10 to 2'b00 subtracts 1. All other single-track changes leave the count unchanged, so A-leading rotation gives +1 per cycle and B-leading rotation gives −1 per cycle.
- R3: With `mode_sel` = 2'b01 (double resolution), every change of A alone steps the count by one. Changes of B alone are ignored.
- R4: With `mode_sel` = 2'b10 (quadruple resolution), every single-track change steps the count by one. For every counting quadrature mode, the step is +1 when the new A level differs from the old B level, which makes the sequence {A,B} = 00→10→11→01→00 count up, and −1 otherwise.
- R5: With `mode_sel` = 2'b11 (pulse mode), a rising edge on A adds 1 and a rising edge on B subtracts 1. Falling edges have no effect, and if both rise in the same cycle the count does not change. `err` is never set in this mode.
- R6: When `idx_en` is high, Z is high and the synchronised {A,B} equals `idx_phase`, `count` takes the value of `preset`. When `idx_en` is low, Z has no effect.
- R7: When `org_en` is high, a preset load additionally requires the origin input to be high.
- R8: When a preset load and a count step fall in the same cycle, the load wins and `count` equals `preset` exactly.
- R9: In the three quadrature modes, a cycle in which A and B both change leaves `count` unchanged and sets `err`. `err` then stays high until reset.
- R10: An input change first shows on `count` after the third rising clock edge that follows it. After the second edge, `count` still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 1 | Track A, or up pulses in pulse mode (asynchronous) |
| b_in | input | 1 | Track B, or down pulses in pulse mode (asynchronous) |
| z_in | input | 1 | Index track (asynchronous) |
| org_in | input | 1 | Homing qualifier input (asynchronous) |
| mode_sel | input | 2 | 00 single, 01 double, 10 quadruple, 11 pulse |
| idx_en | input | 1 | Enables preset load from the index |
| org_en | input | 1 | Requires the homing input for a preset load |
| idx_phase | input | 2 | {A,B} level pair in which a preset load may occur |
| preset | input | 32 | Value loaded into the count |
| count | output | 32 | Registered position count |
| err | output | 1 | Sticky flag for transitions that skip a quadrature state |

## Verification
A wrong previous-state register or a wrong decode shows up on `count` three edges after the offending input change, as an off-by-one or wrong-sign step. The bench therefore compares the count against an arithmetic expectation for every ordered pair of track states in every mode. A stuck or non-sticky `err` shows at the port in the same window. Priority and qualification faults in the preset path show as `count` differing from `preset` in the exact cycle the load is due, which the bench samples on purpose.

// File: rtl/enc_pkg.sv
package enc_pkg;
  typedef enum logic [1:0] {
    M_SINGLE = 2'b00,
    M_DOUBLE = 2'b01,
    M_QUAD   = 2'b10,
    M_PULSE  = 2'b11
  } enc_mode_t;
endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] st [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) st[0] <= '0;
          else     st[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) st[i] <= '0;
          else     st[i] <= st[i-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/enc_decode.sv
module enc_decode
  import enc_pkg::*;
(
  input  enc_mode_t  mode,
  input  logic [1:0] prv,   // {A,B} previous
  input  logic [1:0] cur,   // {A,B} current
  output logic       up,
  output logic       dn,
  output logic       bad
);
  logic [1:0] chg;
  logic       fwd;

  always_comb begin
    chg = prv ^ cur;
    fwd = cur[1] ^ prv[0];
    up  = 1'b0;
    dn  = 1'b0;
    bad = 1'b0;
    case (mode)
      M_PULSE: begin
        // rising on A counts up, rising on B counts down; both cancel
        if ((cur[1] & ~prv[1]) != (cur[0] & ~prv[0])) begin
          up = cur[1] & ~prv[1];
          dn = cur[0] & ~prv[0];
        end
      end
      M_QUAD: begin
        if (chg == 2'b11)      bad = 1'b1;
        else if (chg != 2'b00) begin
          up = fwd;
          dn = ~fwd;
        end
      end
      M_DOUBLE: begin
        if (chg == 2'b11)      bad = 1'b1;
        else if (chg == 2'b10) begin
          up = fwd;
          dn = ~fwd;
        end
      end
      default: begin
        if (chg == 2'b11)                         bad = 1'b1;
        else if (prv == 2'b00 && cur == 2'b10)    up  = 1'b1;
        else if (prv == 2'b10 && cur == 2'b00)    dn  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/enc_counter.sv
module enc_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] preset,
  input  logic         up,
  input  logic         dn,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= preset;
    else if (up)   count <= count + ONE;
    else if (dn)   count <= count - ONE;
  end

  // R8: a load leaves exactly the preset, whatever the step inputs did
  p_load_wins_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(preset)));

  // R4: without a load the count moves by at most one per cycle
  p_step_bounded_r4: assert property (@(posedge clk) disable iff (rst)
    !load |=> (count == $past(count) || count == $past(count) + ONE
               || count == $past(count) - ONE));
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import enc_pkg::*;
#(
  parameter int W    = 32,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         a_in,
  input  logic         b_in,
  input  logic         z_in,
  input  logic         org_in,
  input  logic [1:0]   mode_sel,
  input  logic         idx_en,
  input  logic         org_en,
  input  logic [1:0]   idx_phase,
  input  logic [W-1:0] preset,
  output logic [W-1:0] count,
  output logic         err
);
  logic [3:0] sq;
  logic [1:0] ab_prev;
  logic [1:0] ab_cur;
  logic       z_s, org_s;
  logic       up, dn, bad, load;

  enc_sync #(.N(4), .STAGES(SYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({a_in, b_in, z_in, org_in}),
    .q   (sq)
  );

  assign ab_cur = sq[3:2];
  assign z_s    = sq[1];
  assign org_s  = sq[0];

  always_ff @(posedge clk) begin
    if (rst) ab_prev <= '0;
    else     ab_prev <= ab_cur;
  end

  enc_decode u_dec (
    .mode (enc_mode_t'(mode_sel)),
    .prv  (ab_prev),
    .cur  (ab_cur),
    .up   (up),
    .dn   (dn),
    .bad  (bad)
  );

  assign load = idx_en & z_s & (~org_en | org_s) & (ab_cur == idx_phase);

  enc_counter #(.W(W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .preset (preset),
    .up     (up),
    .dn     (dn),
    .count  (count)
  );

  always_ff @(posedge clk) begin
    if (rst)      err <= 1'b0;
    else if (bad) err <= 1'b1;
  end

  // R9: the error flag never clears outside reset
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R9: a skipped-state transition never moves the count
  p_bad_no_step_r9: assert property (@(posedge clk) disable iff (rst)
    (bad && !load) |=> $stable(count));

  // R4: decoder never asks for both directions at once
  p_dir_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(up && dn));

  // R5: pulse mode never reports a skipped state
  p_pulse_no_err_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b11) |-> !bad);
endmodule

// File: tb/tb_quad_pos_counter.sv
module tb_quad_pos_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        a_in = 0, b_in = 0, z_in = 0, org_in = 0;
  logic [1:0]  mode_sel = 2'b00;
  logic        idx_en = 0, org_en = 0;
  logic [1:0]  idx_phase = 2'b00;
  logic [31:0] preset = '0;
  logic [31:0] count;
  logic        err;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2 clk = ~clk;   // 250 MHz

  quad_pos_counter dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .z_in(z_in),
    .org_in(org_in), .mode_sel(mode_sel), .idx_en(idx_en), .org_en(org_en),
    .idx_phase(idx_phase), .preset(preset), .count(count), .err(err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive_ab(input logic [1:0] v);
    @(negedge clk);
    a_in = v[1];
    b_in = v[0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; a_in = 0; b_in = 0; z_in = 0; org_in = 0;
    wait_n(4);
    rst = 1'b0;
  endtask

  // expected step from the requirements (R2..R5, R9)
  function automatic int exp_delta(input logic [1:0] m, input logic [1:0] p,
                                   input logic [1:0] c, output logic inv);
    logic [1:0] ch;
    int s;
    ch  = p ^ c;
    inv = 1'b0;
    s   = (c[1] != p[0]) ? 1 : -1;
    if (m == 2'b11) begin
      int u, d;
      u = (c[1] && !p[1]) ? 1 : 0;
      d = (c[0] && !p[0]) ? 1 : 0;
      return u - d;
    end
    if (ch == 2'b11) begin inv = 1'b1; return 0; end
    if (ch == 2'b00) return 0;
    if (m == 2'b10) return s;
    if (m == 2'b01) return ch[1] ? s : 0;
    if (p == 2'b00 && c == 2'b10) return 1;
    if (p == 2'b10 && c == 2'b00) return -1;
    return 0;
  endfunction

  initial begin
    logic [31:0] base;
    logic        e0, inv;
    int          d;
    string       tag;

    // R1: reset state
    wait_n(5);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 count", count, 32'd0);
    chk("R1 err", {31'd0, err}, 32'd0);

    // R2..R5, R9: every ordered pair of track states in every mode
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 4; p++) begin
        for (int c = 0; c < 4; c++) begin
          mode_sel = m[1:0];
          do_reset();
          drive_ab(p[1:0]);
          wait_n(4);
          base = count;
          e0   = err;
          drive_ab(c[1:0]);
          wait_n(4);
          d = exp_delta(m[1:0], p[1:0], c[1:0], inv);
          case (m)
            0: tag = "R2";
            1: tag = "R3";
            2: tag = "R4";
            default: tag = "R5";
          endcase
          chk(inv ? "R9 count" : tag, count, base + d);
          chk(m == 3 ? "R5 err" : "R9 err", {31'd0, err}, {31'd0, e0 | inv});
        end
      end
    end

    // R4: a long forward then reverse run in quadruple mode
    mode_sel = 2'b10;
    do_reset();
    begin
      logic [1:0] seq [4];
      seq[0] = 2'b00; seq[1] = 2'b10; seq[2] = 2'b11; seq[3] = 2'b01;
      for (int k = 1; k <= 12; k++) begin
        drive_ab(seq[k % 4]);
        wait_n(4);
      end
      chk("R4 forward run", count, 32'd12);
      for (int k = 11; k >= 0; k--) begin
        drive_ab(seq[k % 4]);
        wait_n(4);
      end
      chk("R4 reverse run", count, 32'd0);
      // wrap below zero
      drive_ab(2'b01);
      wait_n(4);
      chk("R4 wrap", count, 32'hFFFF_FFFF);
    end

    // R9: error stays set after more valid motion
    drive_ab(2'b10);   // 01 -> 10 both change
    wait_n(4);
    chk("R9 no step", count, 32'hFFFF_FFFF);
    drive_ab(2'b11);
    wait_n(4);
    chk("R9 sticky", {31'd0, err}, 32'd1);

    // R10: latency of three edges
    do_reset();
    wait_n(2);
    a_in = 1'b1;            // just after a falling edge
    @(posedge clk); @(posedge clk); #1;
    chk("R10 after two edges", count, 32'd0);
    @(posedge clk); #1;
    chk("R10 after three edges", count, 32'd1);

    // R6, R8: load in phase 11 wins over the step into 11
    do_reset();
    preset    = 32'h1234_5678;
    idx_phase = 2'b11;
    idx_en    = 1'b1;
    z_in      = 1'b1;
    drive_ab(2'b10);
    wait_n(4);
    chk("R6 wrong phase no load", count, 32'd1);
    @(negedge clk);
    a_in = 1'b1; b_in = 1'b1;   // 10 -> 11, also an up step
    @(posedge clk); @(posedge clk); @(posedge clk); #1;
    chk("R8 load beats step", count, 32'h1234_5678);
    z_in = 1'b0;
    drive_ab(2'b01);
    wait_n(4);
    chk("R6 counting resumes", count, 32'h1234_5679);

    // R6: disabled index has no effect
    do_reset();
    idx_en = 1'b0;
    z_in   = 1'b1;
    drive_ab(2'b10); wait_n(4);
    drive_ab(2'b11); wait_n(4);
    chk("R6 disabled", count, 32'd2);

    // R7: homing qualifier
    do_reset();
    idx_en = 1'b1; org_en = 1'b1; z_in = 1'b1; org_in = 1'b0;
    drive_ab(2'b10); wait_n(4);
    drive_ab(2'b11); wait_n(4);
    chk("R7 blocked without origin", count, 32'd2);
    org_in = 1'b1;
    wait_n(4);
    chk("R7 load with origin", count, 32'h1234_5678);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule